// File: doc/BRIEF.md
# Timed Serial Driver Loader

This block sits on the host side of a chain of serial-in, latched-output drivers. Given a parallel word and a one-cycle load request, it produces the three waveforms such a chain needs: serial data, shift clock and latch strobe. Every edge is placed by a down-counter, so the data setup and hold windows, the clock high and low widths, the gap from the last shift clock to the strobe, and the strobe width each meet a minimum. The minimums are given in nanoseconds as parameters and converted to system-clock cycles, rounded up, at elaboration.

The word is shifted out most significant bit first. After the last bit and the clock-to-strobe gap, a strobe pulse copies the chain into its output latches, and a one-cycle done pulse follows. For boards where the latches are transparent (strobe tied high), a per-request mode bit suppresses the strobe pulse. In that mode the controller raises a blanking output for the whole serial entry, then lowers it together with done. Requests that arrive while a transfer is running are dropped.

Top module: `serial_latch_loader`

## Requirements
- R1: After reset and whenever idle, `sclk`, `sstrobe`, `blank`, `busy`, `done` and `sdata` are all 0.
- R2: One accepted request gives exactly WIDTH rising edges of `sclk`, with the word sent MSB first. A receiver that shifts `sdata` into bit 0 on each rising edge (older bits move toward the MSB) then holds the requested word.
- R3: `sdata` holds its value for at least ceil(SETUP_NS/CLK_NS) system cycles before each rising edge of `sclk`.
- R4: `sdata` holds its value for at least ceil(HOLD_NS/CLK_NS) system cycles after each rising edge of `sclk`, and never changes while `sclk` is high.
- R5: Every high phase and every low phase of `sclk` in a transfer lasts at least ceil(PULSE_NS/CLK_NS) cycles, so each data bit is also held at least that long.
- R6: The strobe rises no earlier than ceil(GAP_NS/CLK_NS) cycles after the last rising edge of `sclk`, and `sstrobe` and `sclk` are never high together.
- R7: With `no_strobe`=0, exactly one strobe pulse is issued, at least ceil(STB_NS/CLK_NS) cycles wide. A latch copying the receiver chain at that pulse holds the requested word.
- R8: With `no_strobe`=1 (sampled with the request), no strobe is issued, `blank` is 1 at every rising edge of `sclk`, and `blank` is 0 once done is given. With `no_strobe`=0, `blank` stays 0.
- R9: A load request while `busy` is 1 is ignored: the running transfer completes with its own word and the same WIDTH clock edges, and no extra transfer follows.
- R10: `done` is a single-cycle pulse. It rises in the same cycle that the strobe falls (latched mode) or that `blank` falls (no-strobe mode), and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load request, accepted only while idle |
| word | input | WIDTH | Parallel word captured with the request |
| no_strobe | input | 1 | Transparent-latch mode: no strobe pulse, blank during entry |
| sdata | output | 1 | Serial data to the driver chain |
| sclk | output | 1 | Shift clock to the driver chain |
| sstrobe | output | 1 | Latch strobe to the driver chain |
| blank | output | 1 | Output-blanking enable, high during entry in transparent mode |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Two things can land in the same cycle: a fresh load request and the end of a transfer. A request held on the final strobe cycle is still during busy and must be dropped. A request in the cycle `done` is high finds the block idle and must start a new transfer. The bench pokes load at random points inside running transfers, including directed pokes on the last strobe cycle. It then judges the result by the receiver model's latched word, by the count of clock edges and done pulses per transfer, and by `busy` staying low after completion when no new request was given in the idle state.

// File: rtl/serial_latch_loader.sv
module serial_latch_loader #(
  parameter int WIDTH    = 8,
  parameter int CLK_NS   = 5,
  parameter int SETUP_NS = 75,
  parameter int HOLD_NS  = 75,
  parameter int PULSE_NS = 150,
  parameter int GAP_NS   = 300,
  parameter int STB_NS   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  input  logic             no_strobe,
  output logic             sdata,
  output logic             sclk,
  output logic             sstrobe,
  output logic             blank,
  output logic             busy,
  output logic             done
);
  localparam int SETUP_CYC = (SETUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int HOLD_CYC  = (HOLD_NS  + CLK_NS - 1) / CLK_NS;
  localparam int PULSE_CYC = (PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_CYC   = (GAP_NS   + CLK_NS - 1) / CLK_NS;
  localparam int STB_CYC   = (STB_NS   + CLK_NS - 1) / CLK_NS;
  localparam int LOW_CYC   = (SETUP_CYC > PULSE_CYC ? SETUP_CYC : PULSE_CYC) > 0 ?
                             (SETUP_CYC > PULSE_CYC ? SETUP_CYC : PULSE_CYC) : 1;
  localparam int HIGH_CYC  = (HOLD_CYC > PULSE_CYC ? HOLD_CYC : PULSE_CYC) > 0 ?
                             (HOLD_CYC > PULSE_CYC ? HOLD_CYC : PULSE_CYC) : 1;
  localparam int GAP_C     = GAP_CYC > 0 ? GAP_CYC : 1;
  localparam int STB_C     = STB_CYC > 0 ? STB_CYC : 1;
  localparam int M1        = LOW_CYC > HIGH_CYC ? LOW_CYC : HIGH_CYC;
  localparam int M2        = GAP_C > STB_C ? GAP_C : STB_C;
  localparam int MAXC      = M1 > M2 ? M1 : M2;
  localparam int CW        = $clog2(MAXC + 1);
  localparam int BW        = $clog2(WIDTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_GAP, S_STB} phase_t;

  phase_t           phase;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bits_left;
  logic [WIDTH-1:0] sr;
  logic             mode_q;

  assign busy    = (phase != S_IDLE);
  assign sclk    = (phase == S_HIGH);
  assign sstrobe = (phase == S_STB);
  assign sdata   = (phase == S_LOW || phase == S_HIGH) ? sr[WIDTH-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      sr        <= '0;
      mode_q    <= 1'b0;
      blank     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        S_IDLE: if (load) begin
          phase     <= S_LOW;
          cnt       <= CW'(LOW_CYC - 1);
          bits_left <= BW'(WIDTH - 1);
          sr        <= word;
          mode_q    <= no_strobe;
          blank     <= no_strobe;
        end
        S_LOW: begin
          if (cnt == '0) begin
            phase <= S_HIGH;
            cnt   <= CW'(HIGH_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_HIGH: begin
          if (cnt == '0) begin
            if (bits_left == '0) begin
              phase <= S_GAP;
              cnt   <= CW'(GAP_C - 1);
            end else begin
              phase     <= S_LOW;
              cnt       <= CW'(LOW_CYC - 1);
              sr        <= {sr[WIDTH-2:0], 1'b0};
              bits_left <= bits_left - 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_GAP: begin
          if (cnt == '0) begin
            if (mode_q) begin
              phase <= S_IDLE;
              blank <= 1'b0;
              done  <= 1'b1;
            end else begin
              phase <= S_STB;
              cnt   <= CW'(STB_C - 1);
            end
          end else cnt <= cnt - 1'b1;
        end
        S_STB: begin
          if (cnt == '0) begin
            phase <= S_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_latch_loader_checks #(
  parameter int SETUP_CYC = 15
) (
  input logic clk,
  input logic rst_n,
  input logic sdata,
  input logic sclk,
  input logic sstrobe,
  input logic blank,
  input logic busy,
  input logic done
);
  logic        data_q;
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      run_q  <= 0;
    end else begin
      data_q <= sdata;
      run_q  <= (sdata != data_q) ? 1 : ((run_q < 32'hFFFF) ? run_q + 1 : run_q);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !sstrobe && !blank && !sdata));
  p_setup_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (run_q >= SETUP_CYC && $stable(sdata)));
  p_data_still_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> !sclk);
  p_strobe_clk_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sstrobe && sclk));
  p_blank_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !sstrobe);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(sstrobe) || $fell(blank)));
endmodule

bind serial_latch_loader serial_latch_loader_checks #(.SETUP_CYC(SETUP_CYC)) u_checks (
  .clk(clk), .rst_n(rst_n), .sdata(sdata), .sclk(sclk), .sstrobe(sstrobe),
  .blank(blank), .busy(busy), .done(done)
);

// File: tb/serial_latch_loader_tb.sv
module serial_latch_loader_tb;
  localparam int WIDTH = 8;
  localparam int CLK_NS = 5;

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [WIDTH-1:0] word = '0;
  logic no_strobe = 1'b0;
  logic sdata, sclk, sstrobe, blank, busy, done;

  always #2.5 clk = ~clk;

  serial_latch_loader #(.WIDTH(WIDTH), .CLK_NS(CLK_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word), .no_strobe(no_strobe),
    .sdata(sdata), .sclk(sclk), .sstrobe(sstrobe), .blank(blank), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // receiver model and waveform monitor
  logic [WIDTH-1:0] chain, latched;
  logic cur_mode;
  int rises, strobes, dones;
  logic prev_clk, prev_data, prev_stb, prev_blank, prev_busy;
  int data_run, clk_run, since_rise, stb_run, cycles;

  initial begin
    chain = '0; latched = '0; cur_mode = 0;
    rises = 0; strobes = 0; dones = 0;
    prev_clk = 0; prev_data = 0; prev_stb = 0; prev_blank = 0; prev_busy = 0;
    data_run = 0; clk_run = 0; since_rise = 0; stb_run = 0; cycles = 0;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check("watchdog", 1'b0, cycles, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
    if (rst_n) begin
      if (busy && !prev_busy) begin
        rises = 0; strobes = 0; dones = 0; chain = '0;
      end
      if (sclk && !prev_clk) begin
        check("R3 setup", (data_run >= cyc(75)) && (sdata == prev_data), data_run, cyc(75));
        check("R5 clock low width", clk_run >= cyc(150), clk_run, cyc(150));
        check("R8 blank at shift edge", blank == cur_mode, blank, cur_mode);
        chain = {chain[WIDTH-2:0], sdata};
        rises++;
        since_rise = 0;
      end
      if (!sclk && prev_clk)
        check("R5 clock high width", clk_run >= cyc(150), clk_run, cyc(150));
      if (sdata != prev_data && rises > 0)
        check("R4 hold", since_rise >= cyc(75) && !sclk, since_rise, cyc(75));
      if (sstrobe && !prev_stb) begin
        check("R6 gap to strobe", since_rise >= cyc(300) && !sclk, since_rise, cyc(300));
        strobes++;
        stb_run = 0;
      end
      if (!sstrobe && prev_stb) begin
        check("R7 strobe width", stb_run >= cyc(100), stb_run, cyc(100));
        latched = chain;
      end
      if (done) begin
        dones++;
        check("R10 done coincides with end", (prev_stb && !sstrobe) || (prev_blank && !blank), 0, 1);
      end
      if (!cur_mode && blank) check("R8 blank stays low in latched mode", 1'b0, blank, 0);
      data_run   = (sdata == prev_data) ? data_run + 1 : 1;
      clk_run    = (sclk == prev_clk) ? clk_run + 1 : 1;
      since_rise++;
      if (sstrobe) stb_run++;
    end
    prev_clk = sclk; prev_data = sdata; prev_stb = sstrobe;
    prev_blank = blank; prev_busy = busy;
  end

  task automatic transfer(input logic [WIDTH-1:0] w, input logic mode, input int poke_at);
    int t;
    @(negedge clk);
    cur_mode = mode;
    word = w; no_strobe = mode; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check("R9 busy after request", busy, busy, 1);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      if (t == poke_at) begin
        word = ~w; no_strobe = ~mode; load = 1'b1;
      end else if (load) begin
        load = 1'b0;
      end
      if (poke_at < 0 && sstrobe && u_dut.sstrobe && !done) begin
        // request held on strobe cycles: must be dropped
        word = ~w; load = 1'b1;
      end
    end
    load = 1'b0;
    check("R10 done reached", done, done, 1);
    @(negedge clk);
    #1;
    check("R10 done single cycle", !done, done, 0);
    check("R2 clock edge count", rises == WIDTH, rises, WIDTH);
    check("R2 MSB-first chain content", chain == w, chain, w);
    if (mode) begin
      check("R8 no strobe in transparent mode", strobes == 0, strobes, 0);
      check("R8 blank released", !blank, blank, 0);
    end else begin
      check("R7 single strobe", strobes == 1, strobes, 1);
      check("R7 latched word", latched == w, latched, w);
    end
    check("R10 one done per transfer", dones == 1, dones, 1);
    check("R9 no extra transfer", !busy && !sclk, busy, 0);
    no_strobe = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0001));
    repeat (3) @(negedge clk);
    check("R1 reset sclk", !sclk, sclk, 0);
    check("R1 reset strobe", !sstrobe, sstrobe, 0);
    check("R1 reset blank/busy/done", !blank && !busy && !done, {blank, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle sdata", !sdata && !busy, sdata, 0);
    // directed corners
    transfer(8'hA5, 1'b0, 0);
    transfer(8'h00, 1'b0, 0);
    transfer(8'hFF, 1'b1, 0);
    transfer(8'h81, 1'b0, 40);
    transfer(8'h3C, 1'b0, -1);
    transfer(8'h7E, 1'b1, 300);
    // random
    for (int i = 0; i < 24; i++) begin
      logic [WIDTH-1:0] w;
      logic m;
      int p;
      w = WIDTH'($urandom);
      m = 1'($urandom_range(0, 1));
      p = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 500));
      transfer(w, m, p);
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check("R1 idle at end", !busy && !sclk && !sstrobe && !blank, busy, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule